// File: doc/BRIEF.md
# Rotating Interrupt Message Dispatcher

The dispatcher sits beside a bank of per-input interrupt entries. Each entry is a 64-bit configuration word, and each entry also has a send-pending bit that the bank owns. The dispatcher grants no priority to any entry. It walks the entries in a circle and picks the first eligible entry at or after its scan pointer. An entry is eligible when its pending bit is set and its vector is legal. The dispatcher then captures a message from the fields of that entry and offers it on a valid/ready handshake.

Once the message is handed over, the dispatcher waits for a single response, which either accepts or rejects the message. On acceptance it raises a one-cycle report, tagged with the entry number and trigger kind. The bank uses this report to clear the pending bit and, for level entries, to set its awaiting-service flag. On rejection it reports nothing, and the entry stays pending. In both cases the scan pointer moves to the entry after the one just served, so the search resumes there. Only one message is ever outstanding.

Top module: `irq_msg_dispatch`

## Requirements
- R1: While rst_ni is low, msg_valid_o and acc_o are 0, and the scan pointer restarts at entry 0.
- R2: Selection is round-robin: from idle, the entry picked is the first eligible one found searching upward (with wrap) from the scan pointer.
- R3: The message fields come from the selected entry word: destination = bits 63:56, logical destination flag = bit 11 (0 single target ID, 1 target set), delivery mode = bits 10:8, vector = bits 7:0, level flag = bit 15 (1 level, 0 edge). msg_idx_o gives the entry number.
- R4: From the cycle msg_valid_o rises until the response, all message outputs stay stable. While msg_valid_o is high and msg_ready_i is low, msg_valid_o stays high. After the handshake, msg_valid_o stays low until a response has been taken.
- R5: A response with rsp_ok_i=1 makes acc_o high for exactly the following cycle. During that cycle msg_idx_o names the entry, and acc_level_o equals its level flag.
- R6: A response with rsp_ok_i=0 produces no acc_o. The entry stays pending and is offered again on a later pass.
- R7: After any response, the scan pointer moves to the entry after the one just served, wrapping from N-1 to 0.
- R8: An entry whose vector is below 10h or equal to FFh is never selected, even when pending. With nothing eligible, msg_valid_o stays low.
- R9: rsp_valid_i has no effect unless the dispatcher is waiting after a completed handshake. A response in the same cycle as the handshake is therefore ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_ENTRIES | Send-pending bit per entry |
| entries_i | input | 64*N_ENTRIES | Entry words, entry i at bits 64*i+63:64*i |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Receiver takes the message |
| msg_dest_o | output | 8 | Destination ID or target set |
| msg_logical_o | output | 1 | 1 = target set, 0 = single ID |
| msg_dlv_o | output | 3 | Delivery mode |
| msg_vec_o | output | 8 | Vector |
| msg_level_o | output | 1 | Level-triggered entry |
| msg_idx_o | output | $clog2(N_ENTRIES) | Entry number of message / report |
| rsp_valid_i | input | 1 | Response present |
| rsp_ok_i | input | 1 | 1 = accepted, 0 = rejected |
| acc_o | output | 1 | One-cycle acceptance report |
| acc_level_o | output | 1 | Report concerns a level entry |

## Verification
Two functions can fall in the same cycle: completing the handshake and receiving a response. The bench provokes this by driving msg_ready_i and rsp_valid_i independently at random rates, so a response often lands in the handshake cycle or before it. The reference model ignores such a response, and any acceptance report it causes is flagged as a mismatch. A second overlap can occur when the bank re-raises an entry's pending bit in the same cycle as that entry's acceptance report. Random request masks provoke this, and the model expects the entry to be served again.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int ENTRY_W   = 64;
  localparam int DEST_LSB  = 56;
  localparam int LEVEL_BIT = 15;
  localparam int LOGIC_BIT = 11;
  localparam int DLV_LSB   = 8;
  localparam logic [7:0] VEC_MIN = 8'h10;
  localparam logic [7:0] VEC_MAX = 8'hFE;

  typedef struct packed {
    logic [7:0] dest;
    logic       logical;
    logic [2:0] dlv;
    logic [7:0] vec;
    logic       level;
  } irq_msg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_ACK} disp_state_e;

  function automatic irq_msg_t unpack_entry(input logic [ENTRY_W-1:0] e);
    irq_msg_t m;
    m.dest    = e[DEST_LSB +: 8];
    m.logical = e[LOGIC_BIT];
    m.dlv     = e[DLV_LSB +: 3];
    m.vec     = e[7:0];
    m.level   = e[LEVEL_BIT];
    return m;
  endfunction

  function automatic logic vec_legal(input logic [7:0] v);
    return (v >= VEC_MIN) && (v <= VEC_MAX);
  endfunction
endpackage

// File: rtl/entry_screen.sv
module entry_screen
  import irq_disp_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic [N_ENTRIES-1:0]         pend_i,
  input  logic [N_ENTRIES*ENTRY_W-1:0] entries_i,
  output logic [N_ENTRIES-1:0]         elig_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_scr
    assign elig_o[g] = pend_i[g] && vec_legal(entries_i[g*ENTRY_W +: 8]);
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] elig_i,
  input  logic [IDX_W-1:0]     ptr_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  int j;
  // descending walk so the nearest entry at or after ptr wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    j     = 0;
    for (int k = N_ENTRIES - 1; k >= 0; k--) begin
      j = int'(ptr_i) + k;
      if (j >= N_ENTRIES) j = j - N_ENTRIES;
      if (elig_i[IDX_W'(j)]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/msg_hold.sv
module msg_hold
  import irq_disp_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [IDX_W-1:0]   idx_i,
  output irq_msg_t           msg_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_o <= '0;
      idx_o <= '0;
    end else if (load_i) begin
      msg_o <= unpack_entry(entry_i);
      idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
  import irq_disp_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_ENTRIES-1:0]           pend_i,
  input  logic [N_ENTRIES*64-1:0]        entries_i,
  output logic                           msg_valid_o,
  input  logic                           msg_ready_i,
  output logic [7:0]                     msg_dest_o,
  output logic                           msg_logical_o,
  output logic [2:0]                     msg_dlv_o,
  output logic [7:0]                     msg_vec_o,
  output logic                           msg_level_o,
  output logic [$clog2(N_ENTRIES)-1:0]   msg_idx_o,
  input  logic                           rsp_valid_i,
  input  logic                           rsp_ok_i,
  output logic                           acc_o,
  output logic                           acc_level_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  disp_state_e          state_q;
  logic [IDX_W-1:0]     ptr_q, pick_idx, hold_idx;
  logic [N_ENTRIES-1:0] elig;
  logic                 pick_hit, load;
  irq_msg_t             msg;

  entry_screen #(.N_ENTRIES(N_ENTRIES)) u_screen (
    .pend_i(pend_i), .entries_i(entries_i), .elig_o(elig)
  );

  rr_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .elig_i(elig), .ptr_i(ptr_q), .hit_o(pick_hit), .idx_o(pick_idx)
  );

  assign load = (state_q == ST_IDLE) && pick_hit;

  msg_hold #(.IDX_W(IDX_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .entry_i(entries_i[pick_idx*ENTRY_W +: ENTRY_W]), .idx_i(pick_idx),
    .msg_o(msg), .idx_o(hold_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pick_hit) state_q <= ST_SEND;
        ST_SEND: if (msg_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          ptr_q   <= (hold_idx == LAST) ? '0 : hold_idx + 1'b1;
          state_q <= rsp_ok_i ? ST_ACK : ST_IDLE;
        end
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign msg_valid_o   = (state_q == ST_SEND);
  assign acc_o         = (state_q == ST_ACK);
  assign acc_level_o   = acc_o && msg.level;
  assign msg_dest_o    = msg.dest;
  assign msg_logical_o = msg.logical;
  assign msg_dlv_o     = msg.dlv;
  assign msg_vec_o     = msg.vec;
  assign msg_level_o   = msg.level;
  assign msg_idx_o     = hold_idx;

  // checker-only history
  logic [N_ENTRIES-1:0] pend_d;
  logic                 wait_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d <= '0;
      wait_d <= 1'b0;
    end else begin
      pend_d <= pend_i;
      wait_d <= (state_q == ST_WAIT);
    end
  end

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o &&
      $stable({msg_dest_o, msg_logical_o, msg_dlv_o, msg_vec_o, msg_level_o, msg_idx_o}));

  assert_one_flight_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i |=> !msg_valid_o);

  assert_acc_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o && !msg_valid_o);

  assert_acc_after_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> wait_d && $past(rsp_valid_i && rsp_ok_i));

  assert_vec_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_vec_o >= VEC_MIN) && (msg_vec_o <= VEC_MAX));

  assert_pick_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> pend_d[msg_idx_o]);

  assert_stray_rsp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_o) |-> wait_d);
endmodule

// File: tb/irq_msg_dispatch_tb_top.sv
module irq_msg_dispatch_tb_top;
  timeunit 1ns; timeprecision 1ps;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    pend, pend_set;
  logic [63:0]     cfg [N];
  logic [N*64-1:0] entries;
  logic msg_valid_o, msg_ready_i, msg_logical_o, msg_level_o;
  logic rsp_valid_i, rsp_ok_i, acc_o, acc_level_o;
  logic [7:0] msg_dest_o, msg_vec_o;
  logic [2:0] msg_dlv_o;
  logic [IW-1:0] msg_idx_o;

  always_comb for (int i = 0; i < N; i++) entries[i*64 +: 64] = cfg[i];

  irq_msg_dispatch #(.N_ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .entries_i(entries),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_dest_o(msg_dest_o), .msg_logical_o(msg_logical_o), .msg_dlv_o(msg_dlv_o),
    .msg_vec_o(msg_vec_o), .msg_level_o(msg_level_o), .msg_idx_o(msg_idx_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ok_i(rsp_ok_i),
    .acc_o(acc_o), .acc_level_o(acc_level_o)
  );

  int checks = 0, fails = 0;
  int rdy_pct = 100, rsp_pct = 100, ok_pct = 100;
  int sends [N];
  int accs = 0;
  int order [$];
  bit done = 0;
  bit pv = 0;

  // reference model: 0 idle, 1 offering, 2 awaiting response, 3 reporting
  int ph = 0, cur = 0, ptr = 0;
  logic [63:0] lat = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] d, input logic lg,
                                     input logic [2:0] dm, input logic [7:0] v,
                                     input logic lv);
    return {d, 40'd0, lv, 3'd0, lg, dm, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cur = 0; ptr = 0; pend <= '0;
    end else begin
      logic [N-1:0] clr;
      clr = '0;
      if (ph == 3) clr[cur] = 1'b1;
      case (ph)
        0: begin
          bit found;
          found = 0;
          for (int k = 0; k < N; k++) begin
            int j;
            j = (ptr + k) % N;
            if (!found && pend[j] && cfg[j][7:0] >= 8'h10 && cfg[j][7:0] != 8'hFF) begin
              found = 1; cur = j; lat = cfg[j]; ph = 1;
            end
          end
        end
        1: if (msg_ready_i) ph = 2;
        2: if (rsp_valid_i) begin
          ptr = (cur + 1) % N;
          ph  = rsp_ok_i ? 3 : 0;
        end
        default: ph = 0;
      endcase
      pend <= (pend & ~clr) | pend_set;
    end
  end

  // responder
  always @(negedge clk) begin
    msg_ready_i = ($urandom % 100) < rdy_pct;
    rsp_valid_i = ($urandom % 100) < rsp_pct;
    rsp_ok_i    = ($urandom % 100) < ok_pct;
  end

  // cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2/R4 msg_valid", msg_valid_o, ph == 1);
    chk("R5/R6/R9 acc", acc_o, ph == 3);
    if (ph != 0) begin
      chk("R3 dest", msg_dest_o, lat[63:56]);
      chk("R3 logical", msg_logical_o, lat[11]);
      chk("R3 dlv", msg_dlv_o, lat[10:8]);
      chk("R3 vec", msg_vec_o, lat[7:0]);
      chk("R3 level", msg_level_o, lat[15]);
      chk("R3/R7 idx", msg_idx_o, cur);
    end
    if (ph == 3) chk("R5 acc_level", acc_level_o, lat[15]);
    if (msg_valid_o && !pv) begin
      sends[msg_idx_o]++;
      order.push_back(int'(msg_idx_o));
    end
    pv = msg_valid_o;
    if (acc_o) accs++;
  end

  task automatic raise(input logic [N-1:0] m);
    pend_set = m;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    pend_set = '0;
    msg_ready_i = 0; rsp_valid_i = 0; rsp_ok_i = 0;
    foreach (sends[i]) sends[i] = 0;
    for (int i = 0; i < N; i++)
      cfg[i] = mk(8'h20 + 8'(i), i[0], 3'(i), 8'h30 + 8'(i*4), i >= 4);
    cfg[6] = mk(8'h26, 1'b0, 3'd0, 8'h05, 1'b0);
    cfg[7] = mk(8'h27, 1'b1, 3'd1, 8'hFF, 1'b1);
    wait_cyc(3);
    chk("R1 valid in reset", msg_valid_o, 0);
    chk("R1 acc in reset", acc_o, 0);
    rst_n = 1;
    wait_cyc(2);
    chk("R1 idle after reset", msg_valid_o, 0);

    // all raised, pointer starts at 0: strict upward order, illegal vectors skipped
    order.delete();
    raise('1);
    wait_cyc(60);
    chk("R2 sends in order", order.size(), 6);
    for (int k = 0; k < 6 && k < order.size(); k++) chk("R2/R7 order", order[k], k);
    chk("R8 illegal vec 6 never sent", sends[6], 0);
    chk("R8 illegal vec FF never sent", sends[7], 0);

    // rejection: entries stay pending and are retried
    ok_pct = 0;
    foreach (sends[i]) sends[i] = 0;
    begin
      int a0;
      a0 = accs;
      raise(8'b0000_1010);
      wait_cyc(60);
      chk("R6 entry 1 retried", sends[1] >= 2, 1);
      chk("R6 entry 3 retried", sends[3] >= 2, 1);
      chk("R6 no report on reject", accs - a0, 0);
    end
    ok_pct = 100;
    wait_cyc(20);

    // random traffic: responses collide with handshakes, entries rewritten live
    rdy_pct = 60; rsp_pct = 40; ok_pct = 70;
    for (int r = 0; r < 100; r++) begin
      int e;
      e = $urandom_range(0, N - 1);
      cfg[e] = mk(8'($urandom), 1'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
      raise(N'($urandom));
      wait_cyc(19);
    end

    // nothing eligible, stray responses
    for (int i = 0; i < N; i++) cfg[i][7:0] = 8'h00;
    rdy_pct = 100; rsp_pct = 100; ok_pct = 100;
    wait_cyc(20);
    begin
      int a0, s0;
      a0 = accs; s0 = order.size();
      raise('1);
      wait_cyc(20);
      chk("R9 stray response no report", accs - a0, 0);
      chk("R8 nothing eligible no message", order.size() - s0, 0);
      chk("R8 valid low", msg_valid_o, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule